// File: doc/BRIEF.md
# DRAM Command Request Arbiter

This block sits between a set of per-bank command sources and the single command slot of a DRAM controller. Each source presents a command with an address, a bank address, the three DRAM strobes (cas, ras, we) and three class flags: general command, read, or write. The block picks one eligible source and forwards its fields to a ready/valid output.

Four enable inputs from the controller's scheduler decide which classes may win in a given cycle: reads, writes, general commands, and activates. Activates also need the general command enable. Among the eligible sources, the grant rotates round-robin. The grant is held in a register and steps to the nearest eligible source after the current one. It steps when the output handshake completes, or when nothing is presented on the output.

The block also decodes the forwarded strobes into read, write and activate flags and gives an accept pulse for the scheduler. Timing checks, phase steering and the data path belong to other blocks.

Top module: `dram_cmd_arbiter`

## Requirements
- R1: A source with valid high and is_read high is eligible when want_reads is high. A source with valid high and is_write high is eligible when want_writes is high. A source with valid low is never eligible.
- R2: A source with is_cmd high is eligible only when want_cmds is high. If its strobes encode an activate (ras=1, cas=0, we=0), want_activates must also be high. With want_activates high and want_cmds low, no general command is selected.
- R3: If the granted source is not eligible, out_valid is 0 and out_cas, out_ras and out_we are all 0.
- R4: When out_valid and out_ready are both high at a clock edge, the grant moves to the nearest eligible source with a higher index, wrapping from N_REQ-1 to 0. If no other source is eligible, the grant stays on the current source.
- R5: If the granted source stops being eligible, for example because its valid drops, the grant moves at the next edge to the nearest eligible source after it, without any handshake.
- R6: While out_valid is high and out_ready is low, the grant does not change.
- R7: accept is high exactly when out_valid and out_ready are both high.
- R8: sel_is_read is 1 for strobes cas=1, ras=0, we=0. sel_is_write is 1 for cas=1, ras=0, we=1. sel_is_activate is 1 for cas=0, ras=1, we=0. All three are taken from the forwarded strobes.
- R9: req_ready[i] is high only for the granted index i, and only while out_ready is high.
- R10: Synchronous reset puts the grant on source 0.
- R11: While out_valid is high, out_addr, out_bank and the out_is_* flags equal the granted source's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_REQ | Per-source request valid |
| req_ready | output | N_REQ | Per-source acceptance |
| req_addr | input | N_REQ*ADDR_W | Per-source address, source i at bits [i*ADDR_W +: ADDR_W] |
| req_bank | input | N_REQ*BANK_W | Per-source bank address, source i at bits [i*BANK_W +: BANK_W] |
| req_cas | input | N_REQ | Per-source cas strobe |
| req_ras | input | N_REQ | Per-source ras strobe |
| req_we | input | N_REQ | Per-source we strobe |
| req_is_cmd | input | N_REQ | Source holds a general (non read/write) command |
| req_is_read | input | N_REQ | Source holds a read |
| req_is_write | input | N_REQ | Source holds a write |
| want_reads | input | 1 | Reads may win |
| want_writes | input | 1 | Writes may win |
| want_cmds | input | 1 | General commands may win |
| want_activates | input | 1 | Activates may win (needs want_cmds too) |
| out_valid | output | 1 | Forwarded command valid |
| out_ready | input | 1 | Downstream takes the command |
| out_addr | output | ADDR_W | Forwarded address |
| out_bank | output | BANK_W | Forwarded bank address |
| out_cas | output | 1 | Forwarded cas, 0 when not valid |
| out_ras | output | 1 | Forwarded ras, 0 when not valid |
| out_we | output | 1 | Forwarded we, 0 when not valid |
| out_is_cmd | output | 1 | Forwarded general-command flag |
| out_is_read | output | 1 | Forwarded read flag |
| out_is_write | output | 1 | Forwarded write flag |
| accept | output | 1 | Handshake completes this cycle |
| sel_is_read | output | 1 | Forwarded strobes encode a read |
| sel_is_write | output | 1 | Forwarded strobes encode a write |
| sel_is_activate | output | 1 | Forwarded strobes encode an activate |

## Verification
There are two ways the grant can advance: a completed handshake, and a lost eligibility. These can meet at the same edge. A source can be granted and accepted while its class enable is being filtered. Likewise, a handshake can complete on a source while the enable set hides other sources from the rotation.

The bench provokes both cases. It sweeps all sixteen enable combinations over mixed request patterns and drops out_ready on every third step. In a separate run it withdraws the granted source's valid while out_ready stays low. At each step a bench-side pointer model predicts the forwarded bank and address, the strobes, accept, the decode flags and the per-source ready. Any skipped or repeated grant therefore shows up as a mismatch at the ports.

// File: rtl/cmdarb_pkg.sv
package cmdarb_pkg;

  // Strobe decodes shared by the eligibility filter and the output decoder
  function automatic logic strobe_read(input logic cas, input logic ras, input logic we);
    return cas & ~ras & ~we;
  endfunction

  function automatic logic strobe_write(input logic cas, input logic ras, input logic we);
    return cas & ~ras & we;
  endfunction

  function automatic logic strobe_activate(input logic cas, input logic ras, input logic we);
    return ~cas & ras & ~we;
  endfunction

endpackage

// File: rtl/cmdarb_eligibility.sv
module cmdarb_eligibility #(
  parameter int N_REQ = 8
) (
  input  logic [N_REQ-1:0] valid,
  input  logic [N_REQ-1:0] cas,
  input  logic [N_REQ-1:0] ras,
  input  logic [N_REQ-1:0] we,
  input  logic [N_REQ-1:0] is_cmd,
  input  logic [N_REQ-1:0] is_read,
  input  logic [N_REQ-1:0] is_write,
  input  logic             want_reads,
  input  logic             want_writes,
  input  logic             want_cmds,
  input  logic             want_activates,
  output logic [N_REQ-1:0] eligible
);
  import cmdarb_pkg::*;

  for (genvar gi = 0; gi < N_REQ; gi++) begin : g_src
    logic act_here;
    logic cmd_ok;
    logic rd_ok;
    logic wr_ok;
    assign act_here = strobe_activate(cas[gi], ras[gi], we[gi]);
    assign cmd_ok   = is_cmd[gi] & want_cmds & (~act_here | want_activates);
    assign rd_ok    = is_read[gi] & want_reads;
    assign wr_ok    = is_write[gi] & want_writes;
    assign eligible[gi] = valid[gi] & (cmd_ok | rd_ok | wr_ok);
  end

endmodule

// File: rtl/cmdarb_rr_pointer.sv
module cmdarb_rr_pointer #(
  parameter int N_REQ = 8,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] eligible,
  input  logic             advance,
  output logic [IDX_W-1:0] grant
);
  logic [IDX_W-1:0] grant_q;
  logic [IDX_W-1:0] grant_nxt;

  // Nearest eligible index after the current one; the current index is
  // the last candidate, so a lone eligible source keeps the grant.
  always_comb begin
    grant_nxt = grant_q;
    for (int j = N_REQ; j >= 1; j--) begin
      int k;
      k = int'(grant_q) + j;
      if (k >= N_REQ) k = k - N_REQ;
      if (eligible[k]) grant_nxt = IDX_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
    end else if (advance) begin
      grant_q <= grant_nxt;
    end
  end

  assign grant = grant_q;

endmodule

// File: rtl/cmdarb_out_mux.sv
module cmdarb_out_mux #(
  parameter int N_REQ  = 8,
  parameter int ADDR_W = 13,
  parameter int BANK_W = 3,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [IDX_W-1:0]        grant,
  input  logic [N_REQ-1:0]        eligible,
  input  logic [N_REQ*ADDR_W-1:0] req_addr,
  input  logic [N_REQ*BANK_W-1:0] req_bank,
  input  logic [N_REQ-1:0]        req_cas,
  input  logic [N_REQ-1:0]        req_ras,
  input  logic [N_REQ-1:0]        req_we,
  input  logic [N_REQ-1:0]        req_is_cmd,
  input  logic [N_REQ-1:0]        req_is_read,
  input  logic [N_REQ-1:0]        req_is_write,
  output logic                    out_valid,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [BANK_W-1:0]       out_bank,
  output logic                    out_cas,
  output logic                    out_ras,
  output logic                    out_we,
  output logic                    out_is_cmd,
  output logic                    out_is_read,
  output logic                    out_is_write,
  output logic                    sel_is_read,
  output logic                    sel_is_write,
  output logic                    sel_is_activate
);
  import cmdarb_pkg::*;

  always_comb begin
    out_valid    = eligible[grant];
    out_addr     = req_addr[grant*ADDR_W +: ADDR_W];
    out_bank     = req_bank[grant*BANK_W +: BANK_W];
    out_is_cmd   = req_is_cmd[grant];
    out_is_read  = req_is_read[grant];
    out_is_write = req_is_write[grant];
    // strobes are masked so an idle slot reads as no command
    out_cas      = req_cas[grant] & out_valid;
    out_ras      = req_ras[grant] & out_valid;
    out_we       = req_we[grant]  & out_valid;
  end

  assign sel_is_read     = strobe_read(out_cas, out_ras, out_we);
  assign sel_is_write    = strobe_write(out_cas, out_ras, out_we);
  assign sel_is_activate = strobe_activate(out_cas, out_ras, out_we);

endmodule

// File: rtl/dram_cmd_arbiter.sv
module dram_cmd_arbiter #(
  parameter int N_REQ  = 8,
  parameter int ADDR_W = 13,
  parameter int BANK_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_REQ-1:0]        req_valid,
  output logic [N_REQ-1:0]        req_ready,
  input  logic [N_REQ*ADDR_W-1:0] req_addr,
  input  logic [N_REQ*BANK_W-1:0] req_bank,
  input  logic [N_REQ-1:0]        req_cas,
  input  logic [N_REQ-1:0]        req_ras,
  input  logic [N_REQ-1:0]        req_we,
  input  logic [N_REQ-1:0]        req_is_cmd,
  input  logic [N_REQ-1:0]        req_is_read,
  input  logic [N_REQ-1:0]        req_is_write,
  input  logic                    want_reads,
  input  logic                    want_writes,
  input  logic                    want_cmds,
  input  logic                    want_activates,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [BANK_W-1:0]       out_bank,
  output logic                    out_cas,
  output logic                    out_ras,
  output logic                    out_we,
  output logic                    out_is_cmd,
  output logic                    out_is_read,
  output logic                    out_is_write,
  output logic                    accept,
  output logic                    sel_is_read,
  output logic                    sel_is_write,
  output logic                    sel_is_activate
);
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [N_REQ-1:0] eligible;
  logic [IDX_W-1:0] grant_idx;
  logic             advance;

  cmdarb_eligibility #(.N_REQ(N_REQ)) u_elig (
    .valid          (req_valid),
    .cas            (req_cas),
    .ras            (req_ras),
    .we             (req_we),
    .is_cmd         (req_is_cmd),
    .is_read        (req_is_read),
    .is_write       (req_is_write),
    .want_reads     (want_reads),
    .want_writes    (want_writes),
    .want_cmds      (want_cmds),
    .want_activates (want_activates),
    .eligible       (eligible)
  );

  // Move on after a handshake, or whenever the slot is empty
  assign advance = ~out_valid | out_ready;

  cmdarb_rr_pointer #(.N_REQ(N_REQ)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .eligible (eligible),
    .advance  (advance),
    .grant    (grant_idx)
  );

  cmdarb_out_mux #(.N_REQ(N_REQ), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_mux (
    .grant           (grant_idx),
    .eligible        (eligible),
    .req_addr        (req_addr),
    .req_bank        (req_bank),
    .req_cas         (req_cas),
    .req_ras         (req_ras),
    .req_we          (req_we),
    .req_is_cmd      (req_is_cmd),
    .req_is_read     (req_is_read),
    .req_is_write    (req_is_write),
    .out_valid       (out_valid),
    .out_addr        (out_addr),
    .out_bank        (out_bank),
    .out_cas         (out_cas),
    .out_ras         (out_ras),
    .out_we          (out_we),
    .out_is_cmd      (out_is_cmd),
    .out_is_read     (out_is_read),
    .out_is_write    (out_is_write),
    .sel_is_read     (sel_is_read),
    .sel_is_write    (sel_is_write),
    .sel_is_activate (sel_is_activate)
  );

  for (genvar gi = 0; gi < N_REQ; gi++) begin : g_ready
    assign req_ready[gi] = out_ready & (grant_idx == IDX_W'(gi));
  end

  assign accept = out_valid & out_ready;

endmodule

// File: rtl/dram_cmd_arbiter_chk.sv
module dram_cmd_arbiter_chk #(
  parameter int N_REQ = 8,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_cas,
  input logic             out_ras,
  input logic             out_we,
  input logic             out_is_read,
  input logic             out_is_write,
  input logic             accept,
  input logic             sel_is_activate,
  input logic             want_reads,
  input logic             want_writes,
  input logic             want_cmds,
  input logic             want_activates,
  input logic [N_REQ-1:0] req_ready,
  input logic [IDX_W-1:0] grant_idx
);

  // R9
  one_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));

  // R9
  ready_needs_out_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready != '0) |-> out_ready);

  // R3
  idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_cas && !out_ras && !out_we));

  // R7
  accept_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> (out_valid && out_ready));

  // R6
  hold_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (grant_idx == $past(grant_idx)));

  // R1
  read_class_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_read) |-> want_reads);

  // R1
  write_class_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_write) |-> want_writes);

  // R2
  activate_gate_chk: assert property (@(posedge clk) disable iff (rst)
    sel_is_activate |-> (want_cmds && want_activates));

  // R10
  reset_grant_chk: assert property (@(posedge clk)
    $past(rst) |-> (grant_idx == '0));

endmodule

bind dram_cmd_arbiter dram_cmd_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_cas         (out_cas),
  .out_ras         (out_ras),
  .out_we          (out_we),
  .out_is_read     (out_is_read),
  .out_is_write    (out_is_write),
  .accept          (accept),
  .sel_is_activate (sel_is_activate),
  .want_reads      (want_reads),
  .want_writes     (want_writes),
  .want_cmds       (want_cmds),
  .want_activates  (want_activates),
  .req_ready       (req_ready),
  .grant_idx       (grant_idx)
);

// File: tb/sim_dram_cmd_arbiter.sv
`timescale 1ns/1ps
module sim_dram_cmd_arbiter;
  localparam int N = 8;
  localparam int A = 13;
  localparam int B = 3;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0]   req_valid, req_ready, req_cas, req_ras, req_we;
  logic [N-1:0]   req_is_cmd, req_is_read, req_is_write;
  logic [N*A-1:0] req_addr;
  logic [N*B-1:0] req_bank;
  logic want_reads, want_writes, want_cmds, want_activates;
  logic out_valid, out_ready, out_cas, out_ras, out_we;
  logic [A-1:0] out_addr;
  logic [B-1:0] out_bank;
  logic out_is_cmd, out_is_read, out_is_write, accept;
  logic sel_is_read, sel_is_write, sel_is_activate;

  byte pat [N];
  int  g_model;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  dram_cmd_arbiter #(.N_REQ(N), .ADDR_W(A), .BANK_W(B)) u0 (.*);

  // Request encoding: w write, r read, a activate, p precharge, f refresh, _ idle
  function automatic bit elig_m(int i);
    case (pat[i])
      "w":     return want_writes;
      "r":     return want_reads;
      "a":     return want_cmds && want_activates;
      "p","f": return want_cmds;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] strobes_m(byte c); // {cas,ras,we}
    case (c)
      "w": return 3'b101;
      "r": return 3'b100;
      "a": return 3'b010;
      "p": return 3'b011;
      "f": return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (grant %0d)", tag, act, exp, g_model);
    end
  endtask

  task automatic apply_pat();
    for (int i = 0; i < N; i++) begin
      logic [2:0] s;
      s = strobes_m(pat[i]);
      req_valid[i]    = (pat[i] != "_");
      req_cas[i]      = s[2];
      req_ras[i]      = s[1];
      req_we[i]       = s[0];
      req_is_read[i]  = (pat[i] == "r");
      req_is_write[i] = (pat[i] == "w");
      req_is_cmd[i]   = (pat[i] == "a" || pat[i] == "p" || pat[i] == "f");
      req_addr[i*A +: A] = A'(i * 5 + 1);
      req_bank[i*B +: B] = B'(i);
    end
  endtask

  task automatic step(bit rdy);
    bit v;
    byte c;
    logic [2:0] s;
    out_ready = rdy;
    apply_pat();
    #1;
    v = elig_m(g_model);
    c = pat[g_model];
    s = v ? strobes_m(c) : 3'b000;
    chk("R1/R2 out_valid", int'(out_valid), int'(v));
    chk("R3 strobes", int'({out_cas, out_ras, out_we}), int'(s));
    if (v) begin
      chk("R4/R5/R6 bank", int'(out_bank), g_model);
      chk("R11 addr", int'(out_addr), g_model * 5 + 1);
      chk("R11 flags", int'({out_is_cmd, out_is_read, out_is_write}),
          int'({c == "a" || c == "p" || c == "f", c == "r", c == "w"}));
    end
    chk("R7 accept", int'(accept), int'(v && rdy));
    chk("R8 decode", int'({sel_is_read, sel_is_write, sel_is_activate}),
        int'({v && c == "r", v && c == "w", v && c == "a"}));
    chk("R9 req_ready", int'(req_ready), rdy ? (1 << g_model) : 0);
    @(posedge clk);
    if (!v || rdy) begin
      for (int j = 1; j <= N; j++) begin
        int k;
        k = (g_model + j) % N;
        if (elig_m(k)) begin
          g_model = k;
          break;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    apply_pat();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    g_model = 0;
  endtask

  task automatic load(string s);
    for (int i = 0; i < N; i++) pat[i] = s[i];
  endtask

  initial begin
    string pats [4];
    pats = '{"w_rawpwr", "rp_awrrw", "pr_aa_pw", "afrw_pwa"};
    out_ready = 1'b0;
    {want_reads, want_writes, want_cmds, want_activates} = 4'b0000;
    load("________");
    @(negedge clk);

    // Sweep every enable combination over several request mixes
    for (int p = 0; p < 4; p++) begin
      for (int w = 0; w < 16; w++) begin
        load(pats[p]);
        {want_reads, want_writes, want_cmds, want_activates} = 4'(w);
        do_reset();
        for (int s = 0; s < 10; s++) step(s % 3 != 1);
      end
    end

    // R10: pointer moved, then reset returns it to source 0
    load("pppppppp");
    {want_reads, want_writes, want_cmds, want_activates} = 4'b0010;
    do_reset();
    step(1'b1);
    step(1'b1);
    do_reset();
    out_ready = 1'b0;
    #1;
    chk("R10 bank after reset", int'(out_bank), 0);
    @(negedge clk);

    // R5: withdraw the granted source while out_ready stays low
    for (int n = 0; n < 10; n++) begin
      int idx;
      idx = g_model;
      pat[idx] = "_";
      step(1'b0);
      pat[idx] = "p";
      step(1'b0);
      chk("R5 grant stepped", g_model, (idx + 1) % N);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule